// File: doc/BRIEF.md
# Nonmaskable Interrupt Request Latch

This block turns an asynchronous nonmaskable interrupt pin into a clean, single request for the processor core. The pin passes through a synchronizer. A rising-edge detector then sets a pending flag. The core sees that flag at its next instruction boundary as a one-cycle take pulse. The pulse wins over any maskable request offered in the same cycle and is never gated by the interrupt-enable flag.

The block also holds the interrupt-enable flag that gates maskable sources. A take of either kind clears that flag, and a software set input raises it again. There is no in-service record for the nonmaskable source. A fresh pin edge that arrives while its handler is running is latched and taken again, so handlers nest. A pin level that is already high when reset ends is treated as the resting level, not as an edge.

Top module: `nmi_req_latch`

## Requirements
- R1: While reset is high and on the first cycle after it, `nmi_pending`, `ie_flag`, `nmi_take` and `mask_take` are all 0.
- R2: If `nmi_pin` rises before a clock edge, `nmi_pending` reads 1 after the third following rising clock edge and 0 after the second (two synchronizer stages plus the pending register).
- R3: A pin level held high produces one request only. After `nmi_ack` clears the flag, `nmi_pending` stays 0 while the pin remains high.
- R4: A high pulse on the pin that is sampled by one or more clock edges (widths 1 to 4 cycles) always sets `nmi_pending`.
- R5: If the pin is high throughout a reset lasting at least three cycles and stays high afterwards, no request is made.
- R6: `nmi_take` is 1 exactly when `nmi_pending` and `insn_boundary` are both 1. It does not depend on `ie_flag`.
- R7: `mask_take` is 1 only when `insn_boundary`, `mask_req` and `ie_flag` are 1 and `nmi_pending` is 0. A pending nonmaskable request has priority.
- R8: On the clock edge of a cycle in which either take output is 1, `ie_flag` becomes 0, even if `ie_set` is also 1. Otherwise `ie_set` makes it 1, and with neither it holds its value.
- R9: `nmi_ack` clears `nmi_pending` on the next edge. If a synchronized rising edge is detected in the same cycle as the acknowledge, the flag stays 1.
- R10: A new pin edge that arrives after a take, while `ie_flag` is still 0, sets `nmi_pending` again and is taken at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_pin | input | 1 | Raw asynchronous interrupt pin |
| insn_boundary | input | 1 | Core is at an instruction boundary this cycle |
| nmi_ack | input | 1 | Core acknowledges the nonmaskable request |
| mask_req | input | 1 | Request from the maskable interrupt controller |
| ie_set | input | 1 | Software sets the interrupt-enable flag |
| nmi_pending | output | 1 | Latched nonmaskable request |
| nmi_take | output | 1 | Take the nonmaskable interrupt this cycle |
| mask_take | output | 1 | Take the maskable interrupt this cycle |
| ie_flag | output | 1 | Interrupt-enable flag |

## Verification
A stale or wrongly reset previous-sample register shows up as a spurious pending flag within three cycles of reset release when the pin is high. A lost edge shows up as a missing flag exactly three edges after the pin rises. A wrong arbitration term is visible at once on the take outputs in the same cycle as the boundary strobe. A wrong enable update is visible in `ie_flag` one edge later. The bench sweeps all sixteen combinations of pending, boundary, maskable request and enable, and checks pulse widths from one to four cycles at every edge of the latency window.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic nmi;
        logic mask;
    } take_t;

    function automatic take_t arbitrate(input logic pend, input logic bnd,
                                        input logic mreq, input logic ie);
        take_t t;
        t.nmi  = pend & bnd;
        t.mask = bnd & mreq & ie & ~pend;
        return t;
    endfunction
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= din;
            end else begin : g_next
                always_ff @(posedge clk) chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic ack,
    output logic edge_det,
    output logic pending
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= level;
        else     prev_q <= level;
    end

    assign edge_det = level & ~prev_q & ~rst;

    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= edge_det | (pending & ~ack);
    end

    // R2
    edge_sets_pending_chk: assert property (@(posedge clk) disable iff (rst)
        edge_det |=> pending);
    // R3
    rise_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(edge_det));
    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !edge_det) |=> !pending);
endmodule

// File: rtl/nmi_arbiter.sv
module nmi_arbiter
    import nmi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic boundary,
    input  logic mreq,
    input  logic ie_set,
    output logic take_nmi,
    output logic take_mask,
    output logic ie_q
);
    take_t t;

    always_comb t = arbitrate(pending, boundary, mreq, ie_q);

    assign take_nmi  = t.nmi;
    assign take_mask = t.mask;

    always_ff @(posedge clk) begin
        if (rst)                  ie_q <= 1'b0;
        else if (t.nmi || t.mask) ie_q <= 1'b0;
        else if (ie_set)          ie_q <= 1'b1;
    end

    // R7
    take_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({take_nmi, take_mask}) <= 1);
    // R6
    take_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        take_nmi |-> (pending && boundary));
    // R8
    take_clears_ie_chk: assert property (@(posedge clk) disable iff (rst)
        (take_nmi || take_mask) |=> !ie_q);
endmodule

// File: rtl/nmi_req_latch.sv
module nmi_req_latch
    import nmi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic nmi_pin,
    input  logic insn_boundary,
    input  logic nmi_ack,
    input  logic mask_req,
    input  logic ie_set,
    output logic nmi_pending,
    output logic nmi_take,
    output logic mask_take,
    output logic ie_flag
);
    logic pin_s;
    logic edge_s;

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (nmi_pin),
        .dout (pin_s)
    );

    nmi_edge_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .level    (pin_s),
        .ack      (nmi_ack),
        .edge_det (edge_s),
        .pending  (nmi_pending)
    );

    nmi_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .pending   (nmi_pending),
        .boundary  (insn_boundary),
        .mreq      (mask_req),
        .ie_set    (ie_set),
        .take_nmi  (nmi_take),
        .take_mask (mask_take),
        .ie_q      (ie_flag)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!nmi_pending && !ie_flag));
endmodule

// File: tb/nmi_req_latch_test.sv
`timescale 1ns/1ps
module nmi_req_latch_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_pin = 1'b0, insn_boundary = 1'b0, nmi_ack = 1'b0;
    logic mask_req = 1'b0, ie_set = 1'b0;
    logic nmi_pending, nmi_take, mask_take, ie_flag;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nmi_req_latch uut (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .insn_boundary(insn_boundary),
        .nmi_ack(nmi_ack), .mask_req(mask_req), .ie_set(ie_set),
        .nmi_pending(nmi_pending), .nmi_take(nmi_take),
        .mask_take(mask_take), .ie_flag(ie_flag)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) tick();
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        chk(nmi_pending, 1'b0, "R1 pending in reset");
        chk(ie_flag, 1'b0, "R1 ie in reset");
        do_reset();
        chk(nmi_pending, 1'b0, "R1 pending after reset");
        chk(ie_flag, 1'b0, "R1 ie after reset");
        chk(nmi_take | mask_take, 1'b0, "R1 no take after reset");

        // R2 / R4: pulse widths 1..4, latency at each edge
        for (int w = 1; w <= 4; w++) begin
            nmi_pin = 1'b1;
            for (int k = 1; k <= 6; k++) begin
                tick();
                if (k == w) nmi_pin = 1'b0;
                chk(nmi_pending, (k >= 3), $sformatf("R2 R4 w=%0d k=%0d", w, k));
            end
            nmi_ack = 1'b1;
            tick();
            nmi_ack = 1'b0;
            chk(nmi_pending, 1'b0, "R9 ack clears");
            repeat (3) tick();
        end

        // R3: held level gives one request only
        nmi_pin = 1'b1;
        repeat (3) tick();
        chk(nmi_pending, 1'b1, "R3 held level request");
        nmi_ack = 1'b1;
        tick();
        nmi_ack = 1'b0;
        for (int k = 0; k < 6; k++) begin
            tick();
            chk(nmi_pending, 1'b0, "R3 no retrigger while high");
        end
        nmi_pin = 1'b0;
        repeat (3) tick();

        // R5: high through reset
        nmi_pin = 1'b1;
        do_reset();
        for (int k = 0; k < 6; k++) begin
            chk(nmi_pending, 1'b0, "R5 high through reset");
            tick();
        end
        nmi_pin = 1'b0;
        repeat (3) tick();

        // R6 / R7 / R8 sweep over pending, boundary, mreq, ie
        for (int c = 0; c < 16; c++) begin
            logic p, b, m, i, en, em;
            p = c[3]; b = c[2]; m = c[1]; i = c[0];
            do_reset();
            if (i) begin ie_set = 1'b1; tick(); ie_set = 1'b0; end
            if (p) begin nmi_pin = 1'b1; tick(); nmi_pin = 1'b0; tick(); tick(); end
            chk(ie_flag, i, $sformatf("R8 ie set c=%0d", c));
            chk(nmi_pending, p, $sformatf("R2 setup c=%0d", c));
            insn_boundary = b;
            mask_req = m;
            #1;
            en = p & b;
            em = b & m & i & ~p;
            chk(nmi_take, en, $sformatf("R6 nmi_take c=%0d", c));
            chk(mask_take, em, $sformatf("R7 mask_take c=%0d", c));
            tick();
            insn_boundary = 1'b0;
            mask_req = 1'b0;
            chk(ie_flag, i & ~(en | em), $sformatf("R8 ie after c=%0d", c));
        end

        // R8: clear wins over set
        do_reset();
        nmi_pin = 1'b1; tick(); nmi_pin = 1'b0; tick(); tick();
        insn_boundary = 1'b1;
        ie_set = 1'b1;
        tick();
        insn_boundary = 1'b0;
        ie_set = 1'b0;
        chk(ie_flag, 1'b0, "R8 clear beats set");

        // R9: edge in the same cycle as ack keeps pending
        nmi_pin = 1'b1;
        tick();
        tick();
        nmi_ack = 1'b1;
        tick();
        nmi_ack = 1'b0;
        chk(nmi_pending, 1'b1, "R9 edge with ack");
        nmi_pin = 1'b0;
        nmi_ack = 1'b1;
        tick();
        nmi_ack = 1'b0;
        chk(nmi_pending, 1'b0, "R9 ack alone");

        // R10: nesting while ie is 0
        do_reset();
        nmi_pin = 1'b1; tick(); nmi_pin = 1'b0; tick(); tick();
        insn_boundary = 1'b1;
        nmi_ack = 1'b1;
        #1;
        chk(nmi_take, 1'b1, "R10 first take");
        tick();
        insn_boundary = 1'b0;
        nmi_ack = 1'b0;
        chk(nmi_pending, 1'b0, "R10 cleared by ack");
        nmi_pin = 1'b1; tick(); nmi_pin = 1'b0; tick(); tick();
        chk(nmi_pending, 1'b1, "R10 nested pending");
        chk(ie_flag, 1'b0, "R10 ie still clear");
        insn_boundary = 1'b1;
        #1;
        chk(nmi_take, 1'b1, "R10 nested take");
        tick();
        insn_boundary = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule